// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Register

This block turns a vector of live status lines from a serial controller into a single level interrupt. Every status line is compared with its value at the previous clock edge; a change from low to high latches a sticky cause bit. Cause bits remain set until software clears them by writing ones to them. A mask register selects which causes may drive the interrupt. The interrupt output is the OR of the enabled causes, registered once.

A status that is already high raises no new cause. For that case the registered copy of the status vector is available on its own output, separate from the cause bits. Software can read it before waiting, so it does not wait for an edge that has already happened. A single write port carries both registers: a select bit picks the mask or the cause register, and the data word is as wide as the status vector.

Top module: `evt_cause_ctrl`

## Requirements
- R1: After reset, the cause register, the mask register, the registered status copy and the interrupt output are all zero.
- R2: A status bit that was low at one clock edge and is high at the next sets its cause bit. The new value appears on `cause_o` after that second edge.
- R3: A status bit that stays high sets no cause. Once such a cause has been cleared, it stays clear for as long as the status remains high.
- R4: A write with `wr_sel_i` = 1 clears every cause bit whose data bit is 1 and leaves the cause bits whose data bit is 0 unchanged. An all-ones write clears every cause.
- R5: When a rising edge and a clear for the same cause bit fall on the same clock edge, the bit ends up set.
- R6: A write with `wr_sel_i` = 0 loads the data word into the mask register. Cause writes leave the mask unchanged, and mask writes leave the causes unchanged.
- R7: At each clock edge, `irq_o` takes the OR over all bits of (cause AND mask) as those registers held just before that edge. It therefore follows a change in cause or mask one cycle later.
- R8: While the mask is all zeros, `irq_o` is low one cycle later, whatever the causes hold.
- R9: The first clock edge after reset only samples the status. A status that is already high when reset is released sets no cause.
- R10: `stat_o` shows the status vector sampled at the most recent clock edge. It is zero until the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | NUM_SRC | Live status lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the mask, 1 selects the cause (write one to clear) |
| wr_data_i | input | NUM_SRC | Write data |
| stat_o | output | NUM_SRC | Registered copy of the status vector |
| cause_o | output | NUM_SRC | Sticky cause bits |
| mask_o | output | NUM_SRC | Interrupt enable mask |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default of thirteen status lines. That width gives the random stimulus many combinations of simultaneous edges, partial clears and partial masks on every cycle. It also lets a single bit at the top of the vector be checked on its own, which catches a mistake in width or indexing. The directed cases place an edge and a clear on the same bit in the same cycle. They also hold a status high when reset is released, and hold a status high across a clear.

// File: rtl/evt_cause_pkg.sv
package evt_cause_pkg;
  typedef enum logic {
    SEL_MASK  = 1'b0,
    SEL_CAUSE = 1'b1
  } wsel_e;
endpackage

// File: rtl/evt_edge_sense.sv
module evt_edge_sense #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic [NUM_SRC-1:0] stat_q_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic               primed_o
);
  logic [NUM_SRC-1:0] prev_q, prev_d;
  logic               primed_q, primed_d;

  always_comb begin
    prev_d   = stat_i;
    primed_d = 1'b1;
    rise_o   = primed_q ? (stat_i & ~prev_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  assign stat_q_o = prev_q;
  assign primed_o = primed_q;

  a_r9_no_rise_before_primed: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (rise_o == '0));
endmodule

// File: rtl/evt_cause_bank.sv
module evt_cause_bank #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] cause_o
);
  logic [NUM_SRC-1:0] cause_q, cause_d;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_comb begin
      cause_d[b] = rise_i[b] | (cause_q[b] & ~clr_i[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~rise_i) != '0) |=> ((cause_q & $past(clr_i & ~rise_i)) == '0));
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i == '0) |=> ((cause_q & ~$past(cause_q)) == '0));
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = load_i ? data_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r6_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mask_q));
endmodule

// File: rtl/evt_cause_ctrl.sv
module evt_cause_ctrl #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  import evt_cause_pkg::*;

  wsel_e              sel;
  logic [NUM_SRC-1:0] rise, clr, cause, mask;
  logic               mask_load, primed;
  logic               irq_q, irq_d;

  assign sel       = wsel_e'(wr_sel_i);
  assign mask_load = wr_en_i && (sel == SEL_MASK);
  assign clr       = (wr_en_i && (sel == SEL_CAUSE)) ? wr_data_i : '0;

  evt_edge_sense #(.NUM_SRC(NUM_SRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i),
    .stat_q_o(stat_o), .rise_o(rise), .primed_o(primed)
  );

  evt_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr), .cause_o(cause)
  );

  evt_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .load_i(mask_load), .data_i(wr_data_i), .mask_o(mask)
  );

  always_comb begin
    irq_d = |(cause & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cause_o = cause;
  assign mask_o  = mask;
  assign irq_o   = irq_q;

  a_r8_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq_q);
  a_r7_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(cause) != '0));
  a_r9_first_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> (cause == '0));
  a_r1_reset_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !irq_q);
endmodule

// File: tb/evt_cause_ctrl_bench.sv
module evt_cause_ctrl_bench;
  localparam int N = 13;
  localparam logic [N-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] stat_i = '0;
  logic         wr_en_i = 1'b0;
  logic         wr_sel_i = 1'b0;
  logic [N-1:0] wr_data_i = '0;
  logic [N-1:0] stat_o, cause_o, mask_o;
  logic         irq_o;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_prev, m_cause, m_mask;
  logic         m_primed, m_irq;

  always #10 clk = ~clk;

  evt_cause_ctrl #(.NUM_SRC(N)) u_evt_cause_ctrl (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .stat_o(stat_o),
    .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  function automatic logic [N-1:0] exp_cause(input logic [N-1:0] c, input logic [N-1:0] p,
                                             input logic pr, input logic [N-1:0] s,
                                             input logic [N-1:0] clr);
    logic [N-1:0] r;
    r = pr ? (s & ~p) : '0;
    return r | (c & ~clr);
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [N-1:0] clr;
    logic [N-1:0] n_cause;
    logic         n_irq;
    clr     = (wr_en_i && wr_sel_i) ? wr_data_i : '0;
    n_cause = exp_cause(m_cause, m_prev, m_primed, stat_i, clr);
    n_irq   = |(m_cause & m_mask);
    if (wr_en_i && !wr_sel_i) m_mask = wr_data_i;
    m_cause  = n_cause;
    m_irq    = n_irq;
    m_prev   = stat_i;
    m_primed = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2/R4 cause", cause_o, m_cause);
    chk("R6 mask", mask_o, m_mask);
    chk("R7 irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, m_irq});
    chk("R10 status copy", stat_o, m_prev);
  endtask

  task automatic wr(input logic sel, input logic [N-1:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic do_reset(input logic [N-1:0] s);
    rst_n = 1'b0; stat_i = s; wr_en_i = 1'b0;
    m_prev = '0; m_cause = '0; m_mask = '0; m_primed = 1'b0; m_irq = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset cause", cause_o, '0);
    chk("R1 reset mask", mask_o, '0);
    chk("R1 reset status", stat_o, '0);
    chk("R1 reset irq", {{(N-1){1'b0}}, irq_o}, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R9: status high while reset releases must not set a cause
    do_reset(13'h0005);
    tick();
    chk("R9 no cause from high at reset", cause_o, '0);
    tick();
    chk("R9 still quiet", cause_o, '0);

    // R2 rising edge, R3 held level
    stat_i = '0; tick();
    stat_i = 13'h1000; tick();
    chk("R2 top bit edge", cause_o, 13'h1000);
    wr(1'b1, 13'h1000);
    chk("R4 single clear", cause_o, '0);
    tick(); tick();
    chk("R3 held high no new cause", cause_o, '0);

    // R8 mask zero, R7 enabled cause
    stat_i = 13'h1003; tick();
    tick();
    chk("R8 zero mask no irq", {{(N-1){1'b0}}, irq_o}, '0);
    wr(1'b0, 13'h0002);
    chk("R6 cause unchanged by mask write", cause_o, 13'h0003);
    tick();
    chk("R7 irq raised", {{(N-1){1'b0}}, irq_o}, 13'h1);
    wr(1'b1, 13'h0001);
    chk("R6 mask unchanged by cause write", mask_o, 13'h0002);
    chk("R4 partial clear", cause_o, 13'h0002);

    // R5 set beats clear on same bit
    stat_i = 13'h0000; tick();
    stat_i = 13'h0002;
    wr(1'b1, 13'h0002);
    chk("R5 set wins", cause_o, 13'h0002);

    // R4 clear all
    stat_i = '0; tick();
    stat_i = 13'h0AA0; tick();
    wr(1'b1, ONES);
    chk("R4 clear all", cause_o, '0);
    wr(1'b0, '0);
    tick();
    chk("R8 mask cleared drops irq", {{(N-1){1'b0}}, irq_o}, '0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      stat_i = N'($urandom);
      if (($urandom % 4) == 0) begin
        wr_en_i = 1'b1; wr_sel_i = $urandom % 2; wr_data_i = N'($urandom);
      end else begin
        wr_en_i = 1'b0; wr_data_i = '0;
      end
      tick();
    end
    wr_en_i = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule